// File: doc/BRIEF.md
# Multichannel Scan Mean Smoother

This block takes a stream of interleaved converter samples, one word per accepted transfer, in a fixed scan order of nine slots. Each slot is steered to a logical channel through a fixed remap, and each channel accumulates its samples over a frame of 32 scans (288 samples). When the last sample of a frame is accepted, every channel's frame mean is formed and averaged half-and-half with that channel's previous smoothed value. All nine smoothed values change on the same clock edge.

The smoothed values are read through a combinational channel-indexed port. A second index selects one of the six digital-capable channels and gives a comparator view of it, true above a fixed threshold. The sample input is a valid/ready stream. Once reset has been released, `in_ready` stays high in every cycle, so the block never applies back-pressure. A sample is consumed on each rising edge where `in_valid` and `in_ready` are both high. Cycles with `in_valid` low are gaps and do not advance the scan position.

Top module: `scan_avg_filter`

## Requirements
- R1: While `rst` is high (synchronous, active high), `in_ready` and `frame_done` are 0. After reset all nine smoothed values read 0 and the scan position restarts at slot 0 of scan 0, even if reset came in the middle of a frame.
- R2: `in_ready` is 1 in every cycle after the first clock edge with reset low. A sample counts only on an edge where `in_valid` and `in_ready` are both 1. Data presented with `in_valid` low changes nothing.
- R3: Within a scan, accepted samples 0 to 8 belong to logical channels 2, 4, 3, 6, 5, 7, 1, 0, 8 in that order.
- R4: A frame is 32 scans (288 accepted samples). The edge that accepts its last sample loads all smoothed values at once. `frame_done` is 1 for exactly the following cycle, and the new values are visible in that cycle.
- R5: Only bits [11:0] of `in_data` carry the sample. Bits [15:12] are ignored. A channel's frame mean is floor(sum of its 32 samples / 32).
- R6: A channel's new smoothed value is floor((old smoothed value + frame mean) / 2).
- R7: `rd_value` is the smoothed value of channel `rd_idx`, zero-extended to 16 bits. For `rd_idx` of 9 or more it returns channel 0's value.
- R8: For `dig_idx` 0 to 5, `dig_bit` is 1 exactly when that channel's smoothed value is greater than 200. For `dig_idx` of 6 or more, `dig_bit` is 0.
- R9: Between frame loads the smoothed values hold, including in the cycle where the last sample of a frame is being presented. A sample accepted in the `frame_done` cycle belongs to the next frame, and that frame starts from empty accumulators.
- R10: A frame of all-maximum samples (4095) gives a mean of exactly 4095, with no accumulator wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Sample word present |
| in_ready | output | 1 | Block accepts a sample this cycle |
| in_data | input | 16 | Sample word, conversion result in bits [11:0] |
| frame_done | output | 1 | One-cycle pulse: smoothed values just reloaded |
| rd_idx | input | 4 | Channel index for the value read port |
| rd_value | output | 16 | Smoothed value of the selected channel |
| dig_idx | input | 4 | Channel index for the threshold view |
| dig_bit | output | 1 | Selected channel is above threshold |

## Verification
Two functions can fall in the same cycle: the frame-end load of all smoothed values, and the acceptance of the first sample of the next frame into accumulators that the load has just cleared. The bench sends frames back to back with `in_valid` held high, so that the next frame's first sample is presented during the `frame_done` cycle. It then compares every channel after the following frame with a model that starts that frame from empty sums. It also reads a channel while the last sample of a frame is being presented. That read must still return the old value, and the new value must appear only in the `frame_done` cycle.

// File: rtl/scan_avg_pkg.sv
`timescale 1ns/1ps
package scan_avg_pkg;

  // Scan slot to logical channel steering; slots past the table map to themselves.
  function automatic int unsigned slot_to_chan(input int unsigned slot);
    case (slot)
      0: return 2;
      1: return 4;
      2: return 3;
      3: return 6;
      4: return 5;
      5: return 7;
      6: return 1;
      7: return 0;
      8: return 8;
      default: return slot;
    endcase
  endfunction

  function automatic int unsigned width_of(input int unsigned count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction

endpackage

// File: rtl/scan_slot_seq.sv
`timescale 1ns/1ps
module scan_slot_seq #(
  parameter int unsigned NUM_CH = 9,
  parameter int unsigned SCANS  = 32,
  parameter int unsigned SLOT_W = 4,
  parameter int unsigned SCNT_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  output logic [SLOT_W-1:0] slot,
  output logic              last
);
  localparam logic [SLOT_W-1:0] SLOT_END = SLOT_W'(NUM_CH - 1);
  localparam logic [SCNT_W-1:0] SCAN_END = SCNT_W'(SCANS - 1);

  logic [SLOT_W-1:0] slot_q;
  logic [SCNT_W-1:0] scan_q;
  logic              slot_wrap;

  assign slot_wrap = (slot_q == SLOT_END);
  assign last      = slot_wrap && (scan_q == SCAN_END);
  assign slot      = slot_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      slot_q <= '0;
      scan_q <= '0;
    end else if (take) begin
      if (slot_wrap) begin
        slot_q <= '0;
        scan_q <= (scan_q == SCAN_END) ? '0 : scan_q + 1'b1;
      end else begin
        slot_q <= slot_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/chan_accum.sv
`timescale 1ns/1ps
module chan_accum
  import scan_avg_pkg::*;
#(
  parameter int unsigned NUM_CH = 9,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned ACC_W  = 17,
  parameter int unsigned SLOT_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              take,
  input  logic              last,
  input  logic [SLOT_W-1:0] slot,
  input  logic [DATA_W-1:0] sample,
  output logic [ACC_W-1:0]  sums [NUM_CH]
);
  localparam int unsigned PAD_W = ACC_W - DATA_W;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic             hit;
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W-1:0] addend;

    assign hit    = (slot_to_chan(int'(slot)) == c);
    assign addend = hit ? {{PAD_W{1'b0}}, sample} : '0;
    // Running total including the sample on the input this cycle.
    assign sums[c] = acc_q + addend;

    always_ff @(posedge clk) begin
      if (rst) begin
        acc_q <= '0;
      end else if (take) begin
        acc_q <= last ? '0 : sums[c];
      end
    end
  end
endmodule

// File: rtl/smooth_bank.sv
`timescale 1ns/1ps
module smooth_bank #(
  parameter int unsigned NUM_CH   = 9,
  parameter int unsigned DATA_W   = 12,
  parameter int unsigned ACC_W    = 17,
  parameter int unsigned SCAN_LOG = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ACC_W-1:0]  sums [NUM_CH],
  output logic [DATA_W-1:0] vals [NUM_CH],
  output logic              done
);
  logic done_q;
  assign done = done_q;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DATA_W-1:0] mean;
    logic [DATA_W:0]   pair;
    logic [DATA_W-1:0] val_q;
    logic              unused_lo;

    assign mean      = sums[c][ACC_W-1 -: DATA_W];
    assign unused_lo = ^sums[c][SCAN_LOG-1:0];
    assign pair      = {1'b0, val_q} + {1'b0, mean};
    assign vals[c]   = val_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        val_q <= '0;
      end else if (load) begin
        val_q <= pair[DATA_W:1];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      done_q <= 1'b0;
    end else begin
      done_q <= load;
    end
  end
endmodule

// File: rtl/chan_read_port.sv
`timescale 1ns/1ps
module chan_read_port #(
  parameter int unsigned NUM_CH = 9,
  parameter int unsigned DIG_CH = 6,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned THRESH = 200
) (
  input  logic [DATA_W-1:0] vals [NUM_CH],
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_value,
  input  logic [IDX_W-1:0]  dig_idx,
  output logic              dig_bit
);
  localparam logic [DATA_W-1:0] LIMIT = DATA_W'(THRESH);

  logic [DATA_W-1:0] picked;

  always_comb begin
    picked = vals[0];
    for (int i = 1; i < NUM_CH; i++) begin
      if (rd_idx == IDX_W'(i)) picked = vals[i];
    end
  end

  assign rd_value = {{(WORD_W - DATA_W){1'b0}}, picked};

  always_comb begin
    dig_bit = 1'b0;
    for (int i = 0; i < DIG_CH; i++) begin
      if (dig_idx == IDX_W'(i)) dig_bit = (vals[i] > LIMIT);
    end
  end
endmodule

// File: rtl/scan_avg_filter.sv
`timescale 1ns/1ps
module scan_avg_filter
  import scan_avg_pkg::*;
#(
  parameter int unsigned NUM_CH = 9,
  parameter int unsigned SCANS  = 32,
  parameter int unsigned DIG_CH = 6,
  parameter int unsigned DATA_W = 12,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned THRESH = 200
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  output logic              frame_done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_value,
  input  logic [IDX_W-1:0]  dig_idx,
  output logic              dig_bit
);
  localparam int unsigned SCAN_LOG = $clog2(SCANS);
  localparam int unsigned ACC_W    = DATA_W + SCAN_LOG;
  localparam int unsigned SLOT_W   = width_of(NUM_CH);
  localparam int unsigned SCNT_W   = width_of(SCANS);

  logic              rdy_q;
  logic              take;
  logic              last;
  logic [SLOT_W-1:0] slot;
  logic [ACC_W-1:0]  sums [NUM_CH];
  logic [DATA_W-1:0] vals [NUM_CH];
  logic              unused_hi;

  always_ff @(posedge clk) begin
    if (rst) rdy_q <= 1'b0;
    else     rdy_q <= 1'b1;
  end

  assign in_ready  = rdy_q;
  assign take      = in_valid && rdy_q;
  assign unused_hi = ^in_data[WORD_W-1:DATA_W];

  scan_slot_seq #(
    .NUM_CH(NUM_CH), .SCANS(SCANS), .SLOT_W(SLOT_W), .SCNT_W(SCNT_W)
  ) u_seq (
    .clk(clk), .rst(rst), .take(take), .slot(slot), .last(last)
  );

  chan_accum #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ACC_W(ACC_W), .SLOT_W(SLOT_W)
  ) u_acc (
    .clk(clk), .rst(rst), .take(take), .last(last), .slot(slot),
    .sample(in_data[DATA_W-1:0]), .sums(sums)
  );

  smooth_bank #(
    .NUM_CH(NUM_CH), .DATA_W(DATA_W), .ACC_W(ACC_W), .SCAN_LOG(SCAN_LOG)
  ) u_smooth (
    .clk(clk), .rst(rst), .load(take && last), .sums(sums),
    .vals(vals), .done(frame_done)
  );

  chan_read_port #(
    .NUM_CH(NUM_CH), .DIG_CH(DIG_CH), .DATA_W(DATA_W), .WORD_W(WORD_W),
    .IDX_W(IDX_W), .THRESH(THRESH)
  ) u_rd (
    .vals(vals), .rd_idx(rd_idx), .rd_value(rd_value),
    .dig_idx(dig_idx), .dig_bit(dig_bit)
  );
endmodule

// File: rtl/scan_avg_checker.sv
`timescale 1ns/1ps
module scan_avg_checker #(
  parameter int unsigned NUM_CH = 9,
  parameter int unsigned SCANS  = 32,
  parameter int unsigned DIG_CH = 6,
  parameter int unsigned WORD_W = 16,
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned THRESH = 200
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic              frame_done,
  input logic [IDX_W-1:0]  rd_idx,
  input logic [WORD_W-1:0] rd_value,
  input logic [IDX_W-1:0]  dig_idx,
  input logic              dig_bit
);
  localparam int unsigned FRAME = NUM_CH * SCANS;
  localparam int unsigned CNT_W = $clog2(FRAME + 1);

  logic [CNT_W-1:0] seen_q;
  logic             wrap_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seen_q <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= 1'b0;
      if (in_valid && in_ready) begin
        if (seen_q == CNT_W'(FRAME - 1)) begin
          seen_q <= '0;
          wrap_q <= 1'b1;
        end else begin
          seen_q <= seen_q + 1'b1;
        end
      end
    end
  end

  AST_READY_HOLDS: assert property (@(posedge clk) disable iff (rst)
    in_ready |=> in_ready); // R2
  AST_DONE_ON_FRAME_END: assert property (@(posedge clk) disable iff (rst)
    frame_done == wrap_q); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    frame_done |=> !frame_done); // R4
  AST_VALUE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!frame_done && $stable(rd_idx)) |-> $stable(rd_value)); // R9
  AST_DIG_OUT_OF_RANGE: assert property (@(posedge clk) disable iff (rst)
    (dig_idx >= IDX_W'(DIG_CH)) |-> !dig_bit); // R8
  AST_DIG_MATCHES_VALUE: assert property (@(posedge clk) disable iff (rst)
    ((dig_idx < IDX_W'(DIG_CH)) && (rd_idx == dig_idx)) |->
      (dig_bit == (rd_value > WORD_W'(THRESH)))); // R8
endmodule

bind scan_avg_filter scan_avg_checker #(
  .NUM_CH(NUM_CH), .SCANS(SCANS), .DIG_CH(DIG_CH), .WORD_W(WORD_W),
  .IDX_W(IDX_W), .THRESH(THRESH)
) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
  .frame_done(frame_done), .rd_idx(rd_idx), .rd_value(rd_value),
  .dig_idx(dig_idx), .dig_bit(dig_bit)
);

// File: tb/tb_scan_avg_filter.sv
`timescale 1ns/1ps
module tb_scan_avg_filter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = 16'h0;
  logic        frame_done;
  logic [3:0]  rd_idx = 4'd0;
  logic [15:0] rd_value;
  logic [3:0]  dig_idx = 4'd0;
  logic        dig_bit;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  int model_v [9];
  // R3 slot-to-channel order
  int remap [9] = '{2, 4, 3, 6, 5, 7, 1, 0, 8};
  int consts [9] = '{400, 402, 398, 404, 100, 1000, 0, 4095, 7};

  always #10 clk = ~clk;

  scan_avg_filter dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .frame_done(frame_done), .rd_idx(rd_idx),
    .rd_value(rd_value), .dig_idx(dig_idx), .dig_bit(dig_bit)
  );

  task automatic check(input string req, input string what, input int act, input int expv);
    total++;
    if (act != expv) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  function automatic logic [15:0] samp(input int pat, input int fr, input int scan, input int slot);
    case (pat)
      0: return 16'((slot * 97 + scan * 13 + fr * 211) % 4096);
      1: return 16'(consts[slot]);
      2: return 16'hF000 | 16'((slot * 301 + scan * 7 + fr) % 4096);
      3: return 16'h0FFF;
      default: return 16'hFFFF;
    endcase
  endfunction

  task automatic check_all(input string req);
    for (int c = 0; c < 9; c++) begin
      rd_idx = 4'(c);
      #0.5;
      check(req, $sformatf("rd_value ch%0d", c), int'(rd_value), model_v[c]);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b1;
    in_data = 16'h0ABC;
    repeat (3) @(negedge clk);
    check("R1", "in_ready in reset", int'(in_ready), 0);
    check("R1", "frame_done in reset", int'(frame_done), 0);
    rst = 1'b0;
    in_valid = 1'b0;
    @(negedge clk);
    check("R2", "in_ready after reset", int'(in_ready), 1);
    for (int c = 0; c < 9; c++) model_v[c] = 0;
    check_all("R1");
  endtask

  task automatic send_frame(input int pat, input int fr, input bit gaps, input bit chain, input string req);
    int sums [9];
    int early = 0;
    for (int c = 0; c < 9; c++) sums[c] = 0;
    for (int idx = 0; idx < 288; idx++) begin
      int scan = idx / 9;
      int slot = idx % 9;
      logic [15:0] w;
      if (gaps && (idx % 5 == 2)) begin
        in_valid = 1'b0;
        in_data = 16'hDEAD;
        @(negedge clk);
        if (frame_done) early++;
      end
      if (gaps && idx == 144) check_all("R9");
      if (idx == 287) begin
        rd_idx = 4'd0;
        #0.5;
        check("R9", "old value while last sample presented", int'(rd_value), model_v[0]);
      end
      w = samp(pat, fr, scan, slot);
      sums[remap[slot]] += int'(w & 16'h0FFF);
      in_valid = 1'b1;
      in_data = w;
      @(negedge clk);
      if (idx < 287 && frame_done) early++;
    end
    check("R4", "early frame_done count", early, 0);
    check("R4", "frame_done after last sample", int'(frame_done), 1);
    for (int c = 0; c < 9; c++) model_v[c] = (model_v[c] + sums[c] / 32) / 2;
    if (!chain) begin
      in_valid = 1'b0;
      in_data = 16'h1234;
    end
    check_all(req);
    if (!chain) begin
      @(negedge clk);
      check("R4", "frame_done drops", int'(frame_done), 0);
    end
  endtask

  task automatic t_digital();
    for (int i = 0; i < 16; i++) begin
      dig_idx = 4'(i);
      #0.5;
      check("R8", $sformatf("dig_bit idx%0d", i), int'(dig_bit),
            (i < 6) ? int'(model_v[i] > 200) : 0);
    end
  endtask

  task automatic t_alias();
    for (int i = 9; i < 16; i++) begin
      rd_idx = 4'(i);
      #0.5;
      check("R7", $sformatf("rd_value idx%0d", i), int'(rd_value), model_v[0]);
    end
  endtask

  task automatic t_boundary();
    // R3 R6: distinct constants per slot from zero; ch2=200, ch4=201, ch3=199
    send_frame(1, 0, 1'b0, 1'b0, "R3");
    check("R6", "ch2 half of 400", model_v[2], 200);
    check("R6", "ch4 half of 402", model_v[4], 201);
    t_digital();
    t_alias();
  endtask

  task automatic t_idle();
    in_valid = 1'b0;
    for (int i = 0; i < 30; i++) begin
      in_data = 16'(i * 1111);
      @(negedge clk);
    end
    check_all("R2");
  endtask

  task automatic t_chain();
    // R9: next frame's first sample is accepted in the frame_done cycle
    send_frame(0, 3, 1'b0, 1'b1, "R9");
    send_frame(0, 4, 1'b0, 1'b1, "R9");
    send_frame(1, 5, 1'b0, 1'b0, "R9");
  endtask

  task automatic t_max();
    send_frame(4, 0, 1'b0, 1'b0, "R10");
    send_frame(3, 0, 1'b0, 1'b1, "R10");
    send_frame(4, 0, 1'b0, 1'b0, "R10");
    t_digital();
  endtask

  task automatic t_mid_reset();
    for (int idx = 0; idx < 50; idx++) begin
      in_valid = 1'b1;
      in_data = samp(0, 9, idx / 9, idx % 9);
      @(negedge clk);
    end
    do_reset();
    send_frame(1, 0, 1'b0, 1'b0, "R1");
  endtask

  initial begin
    for (int c = 0; c < 9; c++) model_v[c] = 0;
    do_reset();
    t_boundary();
    t_idle();
    send_frame(0, 1, 1'b1, 1'b0, "R6");
    send_frame(2, 2, 1'b0, 1'b0, "R5");
    t_chain();
    t_max();
    t_alias();
    t_mid_reset();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule